// File: doc/BRIEF.md
# Burst-Gated PN Spreading Shift Register

This block spreads a serial data stream with a pseudo-noise chip sequence. A 16-stage shift register, stepped by the recurrence of x^16 + x^12 + x^5 + x^4 + 1, supplies one chip per step. Each buffered data bit is XORed with the current chip. The resulting coded bit leaves on a registered output together with a valid strobe.

A user-specific starting state is written serially: while the fill selector is high, each enabled clock shifts one seed bit into the leftmost stage in place of the feedback. A shift enable gates every state change of the register and of the sequencer.

Coded bits leave in bursts of 16. After each burst the block idles for two enabled cycles. Incoming bits wait in a small buffer that takes data through a valid/ready handshake. An all-zero state is never used for spreading: it is replaced by the default seed.

Top module: `pn_burst_spreader`

## Requirements
- R1: A synchronous active-high reset sets pn_state to the default seed 0xACE1, drives coded_valid, coded_bit and chip_out low, empties the buffer (data_ready high) and restarts the burst position.
- R2: pn_state bit 15 is the leftmost stage and bit 0 is stage 16. Stage k sits at bit 16-k. On every spreading step the state becomes {fb, state[15:1]}, where fb = state[0]^state[4]^state[11]^state[12] (stages 16, 12, 5, 4). The chip used in that step is state[0] before the step.
- R3: With fill_sel=1 and shift_en=1, the state becomes {seed_bit, state[15:1]}, no coded bit is produced, and the burst position and pause restart from zero. Sixteen such cycles with seed bits s0 first through s15 last leave pn_state equal to the word whose bit i is s_i.
- R4: With shift_en=0, pn_state, the burst position and the pause count do not change and coded_valid goes low. The buffer still accepts data.
- R5: A spreading step happens on a clock edge with shift_en=1, fill_sel=0, a nonzero state, no pause pending and a nonempty buffer. After that edge coded_bit equals the oldest buffered bit XOR the chip, and chip_out equals the chip. Bits leave in arrival order.
- R6: After 16 spreading steps counted since reset or the last fill cycle, the next two enabled run cycles produce no step and leave the state unchanged. Stepping then resumes.
- R7: coded_valid is high for exactly one cycle after each spreading step and low otherwise. coded_bit and chip_out keep their last values while coded_valid is low.
- R8: On an enabled run cycle (fill_sel=0) with an all-zero state, the state is replaced by the default seed 0xACE1 and no coded bit is produced in that cycle.
- R9: The buffer holds two bits. data_ready is high while fewer than two are stored. A bit offered with data_valid and data_ready at an edge can be spread from the next edge on. A bit offered while data_ready is low is dropped.
- R10: When the buffer is empty, an enabled run cycle produces no coded bit and changes neither the state nor the burst position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_sel | input | 1 | 1: leftmost stage takes seed_bit; 0: normal spreading |
| seed_bit | input | 1 | Serial seed input |
| shift_en | input | 1 | Gates all state advance |
| data_valid | input | 1 | Data bit offered |
| data_bit | input | 1 | Data bit to spread |
| data_ready | output | 1 | Buffer has room |
| coded_bit | output | 1 | Spread bit, registered |
| coded_valid | output | 1 | High for one cycle per spread bit |
| chip_out | output | 1 | Chip used for the last spread bit |
| pn_state | output | 16 | Current shift register contents |

## Verification
Every result of this block is due one clock edge after the cycle whose inputs cause it. This holds for a spread bit and its strobe, for a seed bit entering the register, for the default-seed repair and for data_ready dropping after the second push. A pushed bit becomes usable for spreading at the edge after its acceptance. The bench therefore drives inputs 1 ns after an edge, advances its own arithmetic model of the register, buffer and burst/pause count with those inputs, and compares all outputs 1 ns after the following edge. Directed phases cover seeding, enable gating, burst pauses, the zero seed, a full buffer and an empty buffer. A long run with random inputs follows.

// File: rtl/pnsp_pkg.sv
package pnsp_pkg;

  // Action the sequencer requests from the shift register this cycle
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,  // hold state
    OP_FILL = 2'd1,  // shift seed bit into leftmost stage
    OP_FIX  = 2'd2,  // replace an all-zero state by the default seed
    OP_STEP = 2'd3   // advance with feedback, chip consumed
  } lfsr_op_e;

endpackage

// File: rtl/pnsp_lfsr.sv
module pnsp_lfsr
  import pnsp_pkg::*;
#(
  parameter int          W            = 16,
  parameter logic [W-1:0] TAP_MASK     = 16'h1811,
  parameter logic [W-1:0] DEFAULT_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  lfsr_op_e     op,
  input  logic         seed_bit,
  output logic [W-1:0] state,
  output logic         chip,
  output logic         is_zero
);

  logic [W-1:0] sr;
  logic         fb;

  assign fb      = ^(sr & TAP_MASK);
  assign chip    = sr[0];
  assign is_zero = (sr == '0);
  assign state   = sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= DEFAULT_SEED;
    end else begin
      case (op)
        OP_FILL: sr <= {seed_bit, sr[W-1:1]};
        OP_FIX:  sr <= DEFAULT_SEED;
        OP_STEP: sr <= {fb, sr[W-1:1]};
        default: sr <= sr;
      endcase
    end
  end

  // R4: no requested action leaves the register untouched
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE) |=> $stable(sr));

  // R3: a fill cycle moves the seed bit into the leftmost stage
  p_fill_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FILL) |=> (sr[W-1] == $past(seed_bit)) && (sr[W-2:0] == $past(sr[W-1:1])));

  // R8: repair lands on the default seed
  p_zero_repair_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FIX) |=> (sr == DEFAULT_SEED));

  // R2: a step never starts from the all-zero state
  p_step_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STEP) |-> (sr != '0));

endmodule

// File: rtl/pnsp_fifo.sv
module pnsp_fifo #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic din,
  input  logic pop,
  output logic dout,
  output logic empty,
  output logic full
);

  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: a full buffer without a pop stays full (an extra push is dropped)
  p_full_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);

endmodule

// File: rtl/pnsp_burst.sv
module pnsp_burst
  import pnsp_pkg::*;
#(
  parameter int BURST_LEN = 16,
  parameter int HOLD_CYC  = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     shift_en,
  input  logic     fill_sel,
  input  logic     state_zero,
  input  logic     buf_empty,
  output lfsr_op_e op,
  output logic     emit,
  output logic     holding
);

  localparam int PW = (BURST_LEN < 2) ? 1 : $clog2(BURST_LEN);
  localparam int HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);

  logic [PW-1:0] pos;
  logic [HW-1:0] hold_cnt;

  assign holding = (hold_cnt != '0);

  always_comb begin
    op   = OP_IDLE;
    emit = 1'b0;
    if (shift_en) begin
      if (fill_sel)         op = OP_FILL;
      else if (state_zero)  op = OP_FIX;
      else if (holding)     op = OP_IDLE;
      else if (!buf_empty) begin
        op   = OP_STEP;
        emit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      hold_cnt <= '0;
    end else if (op == OP_FILL) begin
      pos      <= '0;
      hold_cnt <= '0;
    end else if (shift_en && !state_zero && holding) begin
      hold_cnt <= hold_cnt - 1'b1;
    end else if (emit) begin
      if (pos == PW'(BURST_LEN - 1)) begin
        pos      <= '0;
        hold_cnt <= HW'(HOLD_CYC);
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  // R6: the last step of a burst arms the pause
  p_pause_armed_r6: assert property (@(posedge clk) disable iff (rst)
    (emit && (pos == PW'(BURST_LEN - 1))) |=> (hold_cnt == HW'(HOLD_CYC)));

  // R4: disabled cycles freeze burst position and pause count
  p_seq_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(pos) && $stable(hold_cnt));

endmodule

// File: rtl/pn_burst_spreader.sv
module pn_burst_spreader
  import pnsp_pkg::*;
#(
  parameter int              LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK     = 16'h1811,
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = 16'hACE1,
  parameter int              BURST_LEN    = 16,
  parameter int              HOLD_CYC     = 2,
  parameter int              BUF_DEPTH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_sel,
  input  logic              seed_bit,
  input  logic              shift_en,
  input  logic              data_valid,
  input  logic              data_bit,
  output logic              data_ready,
  output logic              coded_bit,
  output logic              coded_valid,
  output logic              chip_out,
  output logic [LFSR_W-1:0] pn_state
);

  lfsr_op_e op;
  logic     emit, holding;
  logic     chip, state_zero;
  logic     buf_dout, buf_empty, buf_full;

  pnsp_lfsr #(
    .W(LFSR_W), .TAP_MASK(TAP_MASK), .DEFAULT_SEED(DEFAULT_SEED)
  ) u_lfsr (
    .clk(clk), .rst(rst), .op(op), .seed_bit(seed_bit),
    .state(pn_state), .chip(chip), .is_zero(state_zero)
  );

  pnsp_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push(data_valid), .din(data_bit),
    .pop(emit), .dout(buf_dout), .empty(buf_empty), .full(buf_full)
  );

  pnsp_burst #(.BURST_LEN(BURST_LEN), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst(rst), .shift_en(shift_en), .fill_sel(fill_sel),
    .state_zero(state_zero), .buf_empty(buf_empty),
    .op(op), .emit(emit), .holding(holding)
  );

  assign data_ready = !buf_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      coded_valid <= 1'b0;
      coded_bit   <= 1'b0;
      chip_out    <= 1'b0;
    end else begin
      coded_valid <= emit;
      if (emit) begin
        coded_bit <= buf_dout ^ chip;
        chip_out  <= chip;
      end
    end
  end

  // R5: a strobe only follows an enabled run cycle
  p_valid_after_run_r5: assert property (@(posedge clk) disable iff (rst)
    coded_valid |-> ($past(shift_en) && !$past(fill_sel)));

  // R10: an empty buffer yields no strobe
  p_empty_no_valid_r10: assert property (@(posedge clk) disable iff (rst)
    buf_empty |=> !coded_valid);

  // R6: a pending pause yields no strobe
  p_pause_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
    holding |=> !coded_valid);

  // R7: outputs keep their value between strobes
  p_hold_outputs_r7: assert property (@(posedge clk) disable iff (rst)
    !coded_valid && !$past(rst) |-> $stable(coded_bit) && $stable(chip_out));

endmodule

// File: tb/sim_pn_burst_spreader.sv
module sim_pn_burst_spreader;

  localparam logic [15:0] DEF = 16'hACE1;
  localparam int BUF_D = 2;

  logic clk = 1'b0;
  logic rst, fill_sel, seed_bit, shift_en, data_valid, data_bit;
  logic data_ready, coded_bit, coded_valid, chip_out;
  logic [15:0] pn_state;

  always #10 clk = ~clk;

  pn_burst_spreader u0 (
    .clk(clk), .rst(rst), .fill_sel(fill_sel), .seed_bit(seed_bit),
    .shift_en(shift_en), .data_valid(data_valid), .data_bit(data_bit),
    .data_ready(data_ready), .coded_bit(coded_bit), .coded_valid(coded_valid),
    .chip_out(chip_out), .pn_state(pn_state)
  );

  int checks = 0;
  int fails  = 0;
  string req = "R1";

  // reference model state
  logic [15:0] ms;
  int  mpos, mhold;
  bit  mq[$];
  bit  e_valid, e_code, e_chip;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("coded_valid", int'(coded_valid), int'(e_valid));
    chk("coded_bit", int'(coded_bit), int'(e_code));
    chk("chip_out", int'(chip_out), int'(e_chip));
    chk("pn_state", int'(pn_state), int'(ms));
    chk("data_ready", int'(data_ready), int'(mq.size() < BUF_D));
  endtask

  task automatic do_reset();
    rst = 1'b1; fill_sel = 0; seed_bit = 0; shift_en = 0; data_valid = 0; data_bit = 0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    ms = DEF; mpos = 0; mhold = 0; mq.delete();
    e_valid = 0; e_code = 0; e_chip = 0;
  endtask

  task automatic cyc(input bit fs, input bit sb, input bit en, input bit dv, input bit di);
    bit push;
    bit fb;
    fill_sel = fs; seed_bit = sb; shift_en = en; data_valid = dv; data_bit = di;
    push = dv && (mq.size() < BUF_D);
    e_valid = 0;
    if (en) begin
      if (fs) begin
        ms = {sb, ms[15:1]}; mpos = 0; mhold = 0;
      end else if (ms == 16'h0) begin
        ms = DEF;
      end else if (mhold > 0) begin
        mhold--;
      end else if (mq.size() > 0) begin
        e_valid = 1;
        e_chip  = ms[0];
        e_code  = mq.pop_front() ^ ms[0];
        fb = ms[0] ^ ms[4] ^ ms[11] ^ ms[12];
        ms = {fb, ms[15:1]};
        mpos++;
        if (mpos == 16) begin mpos = 0; mhold = 2; end
      end
    end
    if (push) mq.push_back(di);
    @(posedge clk);
    #1;
    cmp_all();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog expired act=1 exp=0");
    summary();
  end

  initial begin
    int nval;
    do_reset();
    // R1: reset state
    req = "R1";
    cmp_all();
    chk("reset pn_state", int'(pn_state), int'(DEF));

    // R2 R5: continuous data from the default seed
    req = "R2_R5";
    for (int i = 0; i < 200; i++) cyc(0, 0, 1, 1, 1'($urandom_range(0, 1)));

    // R3: serial seed load of 0x1234, bit 0 first
    req = "R3";
    for (int i = 0; i < 16; i++) cyc(1, 1'((16'h1234 >> i) & 1), 1, 0, 0);
    chk("seeded pn_state", int'(pn_state), 16'h1234);
    chk("no strobe during fill", int'(coded_valid), 0);
    for (int i = 0; i < 60; i++) cyc(0, 0, 1, 1, 1'(i % 3 == 0));

    // R4: disable with data arriving
    req = "R4";
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 1, 1'(i & 1));
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0);
    chk("strobe low when disabled", int'(coded_valid), 0);

    // R6 R7: count strobes over long continuous streams
    req = "R6_R7";
    nval = 0;
    for (int i = 0; i < 18 * 20; i++) begin
      cyc(0, 0, 1, 1, 1'($urandom_range(0, 1)));
      nval += int'(coded_valid);
    end
    chk("strobes in 20 bursts", nval, 16 * 20);

    // R8: all-zero seed
    req = "R8";
    for (int i = 0; i < 16; i++) cyc(1, 0, 1, 0, 0);
    chk("zero loaded", int'(pn_state), 0);
    cyc(0, 0, 1, 1, 1);
    chk("repaired seed", int'(pn_state), int'(DEF));
    chk("no strobe on repair", int'(coded_valid), 0);
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 1, 1'(i & 1));

    // R9: fill the buffer while disabled, extra offers dropped
    req = "R9";
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1'(i == 0));
    chk("ready low when full", int'(data_ready), 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 0);

    // R10: empty buffer
    req = "R10";
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, 0, 0);
    chk("no strobe when empty", int'(coded_valid), 0);

    // R1 mid-run reset
    req = "R1";
    for (int i = 0; i < 7; i++) cyc(0, 0, 1, 1, 1);
    do_reset();
    cmp_all();

    // R2 R3 R4 R6 R8 R9: random mixed traffic
    req = "R2_R3_R4_R6_R8_R9_mix";
    for (int i = 0; i < 30000; i++)
      cyc(1'($urandom_range(0, 19) == 0), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 3) != 0),
          1'($urandom_range(0, 1)));

    summary();
  end

endmodule